// File: doc/BRIEF.md
# Foreground Sprite Unit

This block is one foreground sprite engine of a tile-based picture unit. It holds a private copy of a 32-bit sprite attribute word. The copy is taken from attribute memory only while the display is in vertical blanking and only while the host has enabled sprite fetching. Outside that window the cached word cannot change, so a frame is drawn with one consistent sprite state.

For every viewport pixel that is offered, the unit decides whether its 16x16 sprite covers that pixel. Sprite positions are measured against the 320x240 viewport and do not depend on background scroll. Each stored coordinate carries a bias of 16, so a sprite can hang partly off the top or left screen edge. On a hit, the unit mirrors the local column and row as the flip bits require. It then issues one read of the packed tile memory and extracts the 3-bit colour index from the returned word.

The result is one pixel record with a valid flag, a hit flag, the colour index and the palette number. A compositor outside this block ranks many such units.

Top module: `fg_sprite_unit`

## Requirements
- R1: After reset, outValid, hit, tileRdEn, colorIdx and palIdx are 0. The cached word is all zero, which places the sprite fully off-screen, so no pixel hits until a word has been loaded.
- R2: The cache takes attrWord on a clock edge where attrLoad, vblank and fetchEnable are all 1. A load with vblank=0 or fetchEnable=0 has no effect. The word's fields are: bit 31 horizontal flip, bit 30 vertical flip, bits 29..21 X (9 bits), bits 20..13 Y (8 bits), bits 12..10 palette, bits 9..0 tile index.
- R3: A pixel (vx, vy) hits when 0 <= vx+16-X < 16 and 0 <= vy+16-Y < 16. X=16 and Y=16 put the sprite's left and top edges at viewport coordinate 0.
- R4: With X or Y below 16, the sprite is clipped at the left or top edge. Viewport pixel 0 then maps to local column 16-X or local row 16-Y.
- R5: The horizontal flip replaces the local column c with 15-c. The vertical flip replaces the local row r with 15-r. Both are applied before the pixel number is formed.
- R6: The pixel number is p = 16*row + column. The tile read address is 52*tile + floor(p/5).
- R7: tileRdEn is 1 in the cycle after a hitting pixel is sampled, and tileAddr carries the address in that same cycle. No read is requested for a miss or an idle cycle.
- R8: colorIdx is bits [3*(p mod 5)+2 : 3*(p mod 5)] of the tile word that the memory returns one cycle after tileRdEn.
- R9: For a pixel that misses, outValid=1, hit=0, colorIdx=0 and palIdx=0.
- R10: On a hit, palIdx equals the cached palette field.
- R11: outValid is 1 exactly three rising edges after the edge that sampled pixelValid=1, counting the sampling edge as the first. Consecutive pixels stream at one per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel pipeline clock |
| rstN | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Display is in vertical blanking |
| fetchEnable | input | 1 | Host permits the sprite cache to refresh |
| attrLoad | input | 1 | attrWord holds this sprite's attribute word this cycle |
| attrWord | input | 32 | Attribute word from attribute memory |
| pixelValid | input | 1 | A viewport pixel is offered this cycle |
| pixX | input | 9 | Viewport column of the offered pixel |
| pixY | input | 8 | Viewport row of the offered pixel |
| tileRdEn | output | 1 | Tile memory read request |
| tileAddr | output | 16 | Tile memory word address |
| tileData | input | 15 | Tile word, returned one cycle after the request |
| outValid | output | 1 | Pixel record valid |
| hit | output | 1 | Sprite covers the pixel |
| colorIdx | output | 3 | Colour index within the palette |
| palIdx | output | 3 | Palette number |

## Verification
The bound checker checks the timing skeleton on every cycle:
- A read request always follows an offered pixel by one cycle.
- Every hit was preceded two cycles earlier by a read.
- The valid flag trails the pixel strobe by exactly three edges.
- A miss always carries zero colour and palette.

Only the bench scenarios can show that the arithmetic is correct. They cover the bias on both edges, each flip alone and together, the 52-words-per-tile address at the top tile index, and the selection of the 3-bit lane. They also show that loads outside blanking, or with fetching disabled, leave the drawn sprite unchanged.

// File: rtl/fg_sprite_pkg.sv
package fg_sprite_pkg;

  localparam int ATTR_W = 32;
  localparam int POSX_W = 9;
  localparam int POSY_W = 8;
  localparam int PAL_W  = 3;
  localparam int TILE_W = 10;

  // Attribute word layout, most significant field first.
  typedef struct packed {
    logic              hFlip;
    logic              vFlip;
    logic [POSX_W-1:0] posX;
    logic [POSY_W-1:0] posY;
    logic [PAL_W-1:0]  pal;
    logic [TILE_W-1:0] tile;
  } spriteAttr_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cacheLoad;
    logic captureS1;
    logic captureS2;
    logic captureOut;
    logic useData;
  } fgStrobe_t;

endpackage

// File: rtl/fg_sprite_ctrl.sv
module fg_sprite_ctrl
  import fg_sprite_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      vblank,
  input  logic      fetchEnable,
  input  logic      attrLoad,
  input  logic      pixelValid,
  input  logic      coverHit,
  output fgStrobe_t strobe,
  output logic      tileRdEn,
  output logic      outValid,
  output logic      hit
);

  logic s1Valid, s1Hit, s2Valid, s2Hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Hit    <= 1'b0;
      s2Valid  <= 1'b0;
      s2Hit    <= 1'b0;
      outValid <= 1'b0;
      hit      <= 1'b0;
    end else begin
      s1Valid  <= pixelValid;
      s1Hit    <= pixelValid & coverHit;
      s2Valid  <= s1Valid;
      s2Hit    <= s1Hit;
      outValid <= s2Valid;
      hit      <= s2Hit;
    end
  end

  always_comb begin
    strobe.cacheLoad  = attrLoad & vblank & fetchEnable;
    strobe.captureS1  = pixelValid;
    strobe.captureS2  = s1Valid;
    strobe.captureOut = s2Valid;
    strobe.useData    = s2Hit;
  end

  assign tileRdEn = s1Hit;

endmodule

// File: rtl/fg_sprite_datapath.sv
module fg_sprite_datapath
  import fg_sprite_pkg::*;
#(
  parameter int TILE_DIM     = 16,
  parameter int POS_BIAS     = 16,
  parameter int PIX_BITS     = 3,
  parameter int PIX_PER_WORD = 5,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  fgStrobe_t           strobe,
  input  logic [ATTR_W-1:0]   attrWord,
  input  logic [POSX_W-1:0]   pixX,
  input  logic [POSY_W-1:0]   pixY,
  input  logic [DATA_W-1:0]   tileData,
  output logic                coverHit,
  output logic [ADDR_W-1:0]   tileAddr,
  output logic [PIX_BITS-1:0] colorIdx,
  output logic [PAL_W-1:0]    palIdx
);

  localparam int LOC_W          = $clog2(TILE_DIM);
  localparam int P_W            = 2 * LOC_W;
  localparam int WORDS_PER_TILE = (TILE_DIM * TILE_DIM + PIX_PER_WORD - 1) / PIX_PER_WORD;
  localparam int SLOT_W         = $clog2(PIX_PER_WORD);
  localparam int LANES          = 1 << SLOT_W;
  localparam int GX_W           = POSX_W + 2;
  localparam int GY_W           = POSY_W + 2;

  spriteAttr_t cacheQ;

  always_ff @(posedge clk) begin
    if (!rstN)                 cacheQ <= '0;
    else if (strobe.cacheLoad) cacheQ <= spriteAttr_t'(attrWord);
  end

  // Stage 1 geometry: local offset wraps to a large unsigned value when negative.
  logic [GX_W-1:0]   dx;
  logic [GY_W-1:0]   dy;
  logic              insideX, insideY;
  logic [LOC_W-1:0]  col, row;
  logic [P_W-1:0]    pixNum;
  logic [ADDR_W-1:0] pExt, wordOff, addrNext;
  logic [SLOT_W-1:0] slotNext;

  always_comb begin
    dx       = GX_W'(pixX) + GX_W'(POS_BIAS) - GX_W'(cacheQ.posX);
    dy       = GY_W'(pixY) + GY_W'(POS_BIAS) - GY_W'(cacheQ.posY);
    insideX  = dx < GX_W'(TILE_DIM);
    insideY  = dy < GY_W'(TILE_DIM);
    col      = cacheQ.hFlip ? LOC_W'(TILE_DIM - 1) - dx[LOC_W-1:0] : dx[LOC_W-1:0];
    row      = cacheQ.vFlip ? LOC_W'(TILE_DIM - 1) - dy[LOC_W-1:0] : dy[LOC_W-1:0];
    pixNum   = {row, col};
    pExt     = ADDR_W'(pixNum);
    wordOff  = pExt / ADDR_W'(PIX_PER_WORD);
    slotNext = SLOT_W'(pExt % ADDR_W'(PIX_PER_WORD));
    addrNext = ADDR_W'(cacheQ.tile) * ADDR_W'(WORDS_PER_TILE) + wordOff;
  end

  assign coverHit = insideX & insideY;

  logic [SLOT_W-1:0] s1Slot, s2Slot;
  logic [PAL_W-1:0]  s1Pal, s2Pal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tileAddr <= '0;
      s1Slot   <= '0;
      s1Pal    <= '0;
    end else if (strobe.captureS1) begin
      tileAddr <= addrNext;
      s1Slot   <= slotNext;
      s1Pal    <= cacheQ.pal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Slot <= '0;
      s2Pal  <= '0;
    end else if (strobe.captureS2) begin
      s2Slot <= s1Slot;
      s2Pal  <= s1Pal;
    end
  end

  // Stage 3: lane select from the returned word, padded to a power of two.
  logic [PIX_BITS-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g < PIX_PER_WORD) begin : gReal
      assign lane[g] = tileData[g*PIX_BITS +: PIX_BITS];
    end else begin : gPad
      assign lane[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorIdx <= '0;
      palIdx   <= '0;
    end else if (strobe.captureOut && strobe.useData) begin
      colorIdx <= lane[s2Slot];
      palIdx   <= s2Pal;
    end else begin
      colorIdx <= '0;
      palIdx   <= '0;
    end
  end

endmodule

// File: rtl/fg_sprite_unit.sv
module fg_sprite_unit
  import fg_sprite_pkg::*;
#(
  parameter int TILE_DIM     = 16,
  parameter int POS_BIAS     = 16,
  parameter int PIX_BITS     = 3,
  parameter int PIX_PER_WORD = 5,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                vblank,
  input  logic                fetchEnable,
  input  logic                attrLoad,
  input  logic [31:0]         attrWord,
  input  logic                pixelValid,
  input  logic [8:0]          pixX,
  input  logic [7:0]          pixY,
  output logic                tileRdEn,
  output logic [ADDR_W-1:0]   tileAddr,
  input  logic [DATA_W-1:0]   tileData,
  output logic                outValid,
  output logic                hit,
  output logic [PIX_BITS-1:0] colorIdx,
  output logic [2:0]          palIdx
);

  fgStrobe_t strobe;
  logic      coverHit;

  fg_sprite_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .vblank      (vblank),
    .fetchEnable (fetchEnable),
    .attrLoad    (attrLoad),
    .pixelValid  (pixelValid),
    .coverHit    (coverHit),
    .strobe      (strobe),
    .tileRdEn    (tileRdEn),
    .outValid    (outValid),
    .hit         (hit)
  );

  fg_sprite_datapath #(
    .TILE_DIM     (TILE_DIM),
    .POS_BIAS     (POS_BIAS),
    .PIX_BITS     (PIX_BITS),
    .PIX_PER_WORD (PIX_PER_WORD),
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .attrWord (attrWord),
    .pixX     (pixX),
    .pixY     (pixY),
    .tileData (tileData),
    .coverHit (coverHit),
    .tileAddr (tileAddr),
    .colorIdx (colorIdx),
    .palIdx   (palIdx)
  );

endmodule

// File: rtl/fg_sprite_checker.sv
module fg_sprite_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pixelValid,
  input logic       tileRdEn,
  input logic       outValid,
  input logic       hit,
  input logic [2:0] colorIdx,
  input logic [2:0] palIdx
);

  assert_read_follows_pixel_R7: assert property (@(posedge clk) disable iff (!rstN)
    tileRdEn |-> $past(pixelValid));

  assert_hit_had_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $past(tileRdEn, 2));

  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(pixelValid, 3));

  assert_idle_stays_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pixelValid, 3) |-> !outValid);

  assert_miss_is_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !hit) |-> (colorIdx == 3'd0 && palIdx == 3'd0));

  assert_hit_only_when_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> outValid);

endmodule

bind fg_sprite_unit fg_sprite_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pixelValid (pixelValid),
  .tileRdEn   (tileRdEn),
  .outValid   (outValid),
  .hit        (hit),
  .colorIdx   (colorIdx),
  .palIdx     (palIdx)
);

// File: tb/fg_sprite_unit_bench.sv
`timescale 1ns/1ps
module fg_sprite_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vblank = 1'b0;
  logic        fetchEnable = 1'b0;
  logic        attrLoad = 1'b0;
  logic [31:0] attrWord = '0;
  logic        pixelValid = 1'b0;
  logic [8:0]  pixX = '0;
  logic [7:0]  pixY = '0;
  logic        tileRdEn;
  logic [15:0] tileAddr;
  logic [14:0] tileData = '0;
  logic        outValid, hit;
  logic [2:0]  colorIdx, palIdx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench view of what the cache must hold.
  logic [31:0] modelAttr = '0;

  always #2.5 clk = ~clk;

  fg_sprite_unit u_fg_sprite_unit (
    .clk(clk), .rstN(rstN), .vblank(vblank), .fetchEnable(fetchEnable),
    .attrLoad(attrLoad), .attrWord(attrWord), .pixelValid(pixelValid),
    .pixX(pixX), .pixY(pixY), .tileRdEn(tileRdEn), .tileAddr(tileAddr),
    .tileData(tileData), .outValid(outValid), .hit(hit),
    .colorIdx(colorIdx), .palIdx(palIdx)
  );

  function automatic logic [14:0] memWord(input logic [15:0] a);
    logic [15:0] m;
    m = (a * 16'd40503) ^ 16'h5a3c;
    return m[14:0];
  endfunction

  always @(posedge clk) if (tileRdEn) tileData <= memWord(tileAddr);

  function automatic logic [31:0] mkAttr(input bit hf, input bit vf, input int x,
                                         input int y, input int pal, input int tile);
    logic [8:0] xs; logic [7:0] ys; logic [2:0] ps; logic [9:0] ts;
    xs = 9'(x); ys = 8'(y); ps = 3'(pal); ts = 10'(tile);
    return {hf, vf, xs, ys, ps, ts};
  endfunction

  task automatic model(input int vx, input int vy, output bit h, output int addr,
                       output int col, output int pal);
    int x, y, dx, dy, c, r, p, t;
    x = int'(modelAttr[29:21]); y = int'(modelAttr[20:13]);
    t = int'(modelAttr[9:0]);
    dx = vx + 16 - x; dy = vy + 16 - y;
    h = (dx >= 0 && dx < 16 && dy >= 0 && dy < 16);
    c = modelAttr[31] ? 15 - dx : dx;
    r = modelAttr[30] ? 15 - dy : dy;
    p = r * 16 + c;
    addr = 52 * t + p / 5;
    col = h ? int'((memWord(16'(addr)) >> (3 * (p % 5))) & 15'd7) : 0;
    pal = h ? int'(modelAttr[12:10]) : 0;
  endtask

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic loadAttr(input logic [31:0] w, input bit vb, input bit fe);
    @(negedge clk);
    attrWord = w; vblank = vb; fetchEnable = fe; attrLoad = 1'b1;
    @(posedge clk);
    @(negedge clk);
    attrLoad = 1'b0; vblank = 1'b0; fetchEnable = 1'b0;
    if (vb && fe) modelAttr = w;
  endtask

  task automatic probe(input int vx, input int vy, input string tag);
    bit h; int addr, col, pal;
    model(vx, vy, h, addr, col, pal);
    @(negedge clk);
    pixelValid = 1'b1; pixX = 9'(vx); pixY = 8'(vy);
    @(posedge clk);
    @(negedge clk);
    pixelValid = 1'b0;
    cmp(tag, "tileRdEn (R7)", int'(tileRdEn), int'(h));
    if (h) cmp(tag, "tileAddr (R6)", int'(tileAddr), addr);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "outValid (R11)", int'(outValid), 1);
    cmp(tag, "hit", int'(hit), int'(h));
    cmp(tag, "colorIdx (R8)", int'(colorIdx), col);
    cmp(tag, "palIdx (R10)", int'(palIdx), pal);
  endtask

  task automatic tReset();
    cmp("R1", "outValid", int'(outValid), 0);
    cmp("R1", "hit", int'(hit), 0);
    cmp("R1", "tileRdEn", int'(tileRdEn), 0);
    cmp("R1", "colorIdx", int'(colorIdx), 0);
    cmp("R1", "palIdx", int'(palIdx), 0);
    probe(0, 0, "R1");
    probe(100, 100, "R1");
  endtask

  task automatic tBasic();
    loadAttr(mkAttr(0, 0, 16, 16, 3, 5), 1, 1);
    probe(0, 0, "R3");
    probe(15, 15, "R3");
    probe(7, 9, "R6");
    probe(16, 0, "R3");
    probe(0, 16, "R9");
  endtask

  task automatic tIgnored();
    loadAttr(mkAttr(0, 0, 200, 100, 6, 9), 0, 1);
    probe(0, 0, "R2");
    loadAttr(mkAttr(1, 1, 200, 100, 6, 9), 1, 0);
    probe(0, 0, "R2");
    probe(184, 84, "R2");
  endtask

  task automatic tEdgeClip();
    loadAttr(mkAttr(0, 0, 10, 4, 2, 77), 1, 1);
    probe(0, 0, "R4");
    probe(9, 3, "R4");
    probe(10, 0, "R4");
    probe(0, 4, "R4");
    loadAttr(mkAttr(0, 0, 335, 250, 1, 12), 1, 1);
    probe(319, 234, "R3");
    probe(318, 234, "R3");
  endtask

  task automatic tFlips();
    loadAttr(mkAttr(1, 0, 116, 66, 4, 300), 1, 1);
    probe(100, 50, "R5");
    probe(103, 57, "R5");
    loadAttr(mkAttr(0, 1, 116, 66, 4, 300), 1, 1);
    probe(100, 50, "R5");
    probe(112, 61, "R5");
    loadAttr(mkAttr(1, 1, 116, 66, 7, 301), 1, 1);
    probe(100, 50, "R5");
    probe(115, 65, "R5");
  endtask

  task automatic tTopTile();
    loadAttr(mkAttr(0, 0, 16, 16, 5, 1023), 1, 1);
    probe(15, 15, "R6");
    probe(14, 15, "R8");
    probe(3, 0, "R8");
  endtask

  task automatic tStream();
    bit eh[4]; int ea[4], ec[4], ep[4];
    loadAttr(mkAttr(0, 0, 30, 20, 6, 40), 1, 1);
    for (int i = 0; i < 4; i++) model(27 + 2 * i, 5, eh[i], ea[i], ec[i], ep[i]);
    for (int cyc = 0; cyc < 8; cyc++) begin
      @(negedge clk);
      if (cyc < 4) begin
        pixelValid = 1'b1; pixX = 9'(27 + 2 * cyc); pixY = 8'd5;
      end else pixelValid = 1'b0;
      if (cyc >= 3 && cyc < 7) begin
        cmp("R11", "stream outValid", int'(outValid), 1);
        cmp("R11", "stream hit", int'(hit), int'(eh[cyc-3]));
        cmp("R11", "stream colorIdx", int'(colorIdx), ec[cyc-3]);
        cmp("R11", "stream palIdx", int'(palIdx), ep[cyc-3]);
      end
      if (cyc == 7) cmp("R11", "stream drained", int'(outValid), 0);
    end
  endtask

  task automatic tIdle();
    repeat (5) @(posedge clk);
    @(negedge clk);
    cmp("R11", "idle outValid", int'(outValid), 0);
    cmp("R7", "idle tileRdEn", int'(tileRdEn), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tIgnored();
    tEdgeClip();
    tFlips();
    tTopTile();
    tStream();
    tIdle();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule